// File: doc/BRIEF.md
# Seven-Source Prioritised Vectored Interrupt Controller

This block collects interrupt requests from seven sources and offers one vector at a time to a processor core. Two of the sources are external active-low pins. Each pin can be set to edge or level sensing. Two are timer overflow flags, and three are OR-combined peripheral flag pairs. Every source has its own enable, and one global enable masks them all.

Each source is given one of four priority levels by a pair of bits: the high bit is the most significant bit of the level and the low bit is the least significant bit. Among eligible requests the highest level wins. Ties at that level go to the source earliest in a fixed polling order.

The winner is offered on a valid/ready pair:
- `irq_valid` is high while an eligible request exists, and `irq_vector` carries its address.
- A transfer occurs on a clock edge where `irq_valid` and `irq_ready` are both high. Flag clearing and in-service recording happen only on that edge.
- While `irq_ready` is low, nothing inside the block changes because of the offer.
- Before acceptance the offered vector may change, but only when the set of eligible requests changes.

A one-cycle `reti` strobe marks the end of a service routine.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_valid` is low, no level is in service and all hardware-held flags are clear.
- R2: A source can be offered only while `gie` is high and its `src_en` bit is high. With either low, its request produces no `irq_valid`.
- R3: When eligible requests at different levels are present together, the one with the higher level (`{prio_hi[i],prio_lo[i]}`, 3 highest) is offered.
- R4: Within one level the polling order is source index 0 (external 0), 1 (timer 0), 2 (external 1), 3 (timer 1), 4 (serial), 5 (SPI/ADC), 6 (PCA/LVF). Index 0 is first. Source i is offered with vector 16'h0003 + 8*i.
- R5: A request is offered only if its level is strictly above every level in service. An accepted vector marks its level as in service, so requests at the same or a lower level wait.
- R6: A `reti` pulse removes only the highest level from the in-service set. A lower in-service level keeps blocking.
- R7: With `ext_edge[k]` high, a falling edge on `ext_pin_n[k]` sets a flag after a two-flop synchroniser. The flag stays set until that vector is accepted or `hw_flag_clr` writes it. Acceptance clears it.
- R8: With `ext_edge[k]` low, the request follows the synchronised pin being low, and acceptance does not clear it.
- R9: A pulse on `tmr_ovf[t]` sets the timer flag, and accepting the timer's vector clears it.
- R10: The serial request is `ser_rx|ser_tx`, the SPI/ADC request is `spi_flag|adc_flag` and the PCA/LVF request is `pca_flag|lvf_flag`. Acceptance does not clear any of them.
- R11: `hw_flag_clr` bit i clears the held flag of source i (bits 0..3 = external 0, timer 0, external 1, timer 1). A hardware set in the same cycle wins over the clear.
- R12: Without `irq_ready`, an offered request stays offered and no flag or in-service state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gie | input | 1 | Global interrupt enable |
| src_en | input | 7 | Per-source enable, bit index = source index |
| prio_hi | input | 7 | Priority level high bit per source |
| prio_lo | input | 7 | Priority level low bit per source |
| ext_pin_n | input | 2 | Active-low external request pins (bit 0 = external 0) |
| ext_edge | input | 2 | 1 = falling-edge sensing, 0 = level sensing |
| tmr_ovf | input | 2 | Timer overflow set pulses (bit 0 = timer 0) |
| hw_flag_clr | input | 4 | Software clear strobes for held flags of sources 0..3 |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| spi_flag | input | 1 | SPI flag |
| adc_flag | input | 1 | ADC flag |
| pca_flag | input | 1 | PCA flag |
| lvf_flag | input | 1 | Low-voltage flag |
| irq_valid | output | 1 | A vector is being offered |
| irq_ready | input | 1 | Core accepts the offered vector |
| irq_vector | output | 16 | Vector address of the offered source |
| reti | input | 1 | Return-from-interrupt strobe |

## Verification
The assertions assume the sensing mode bits do not change while a flag is being set or cleared. They also assume `reti` is pulsed only while some level is in service. The stimulus holds `ext_edge` fixed for the whole run and pairs every `reti` with an earlier accepted vector. Pin changes are spaced wider than the synchroniser depth, so each falling edge is seen exactly once.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC = 7;
  localparam int NLVL = 4;
  localparam int LVLW = $clog2(NLVL);
  localparam int IDXW = $clog2(NSRC);
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;
  // source indices in polling order (lowest index polled first)
  localparam int S_EXT0 = 0;
  localparam int S_TMR0 = 1;
  localparam int S_EXT1 = 2;
  localparam int S_TMR1 = 3;
  localparam int S_SER  = 4;
  localparam int S_SPAD = 5;
  localparam int S_PCLV = 6;
  typedef logic [LVLW-1:0] lvl_t;
  typedef logic [IDXW-1:0] idx_t;
endpackage

// File: rtl/irqc_ext_detect.sv
module irqc_ext_detect #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic take_clr,
  input  logic sw_clr,
  output logic req
);
  logic [SYNC:0] sh;
  logic          synced, fall, flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[SYNC-1:0], pin_n};
  end

  assign synced = sh[SYNC-1];
  assign fall   = sh[SYNC] & ~synced;

  // set wins over any clear; level mode keeps the held flag empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag <= 1'b0;
    else if (!edge_mode)         flag <= 1'b0;
    else if (fall)               flag <= 1'b1;
    else if (take_clr || sw_clr) flag <= 1'b0;
  end

  assign req = edge_mode ? flag : ~synced;

  // R7: acceptance in edge mode drops the request unless a new edge lands
  a_r7_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && take_clr && !fall) |=> (!req || !edge_mode));
  // R11: simultaneous set and software clear leaves the request up
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && fall && sw_clr) |=> (req || !edge_mode));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic [NSRC-1:0]            req,
  input  logic [NSRC-1:0][LVLW-1:0]  src_lvl,
  input  logic [NLVL-1:0]            in_service,
  output logic                       win_valid,
  output idx_t                       win_idx,
  output lvl_t                       win_lvl
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int l = NLVL-1; l >= 0; l--) begin
      for (int i = 0; i < NSRC; i++) begin
        if (!win_valid && req[i] && (src_lvl[i] == lvl_t'(l)) &&
            ((in_service >> l) == '0)) begin
          win_valid = 1'b1;
          win_idx   = idx_t'(i);
          win_lvl   = lvl_t'(l);
        end
      end
    end
  end
endmodule

// File: rtl/irqc_nest.sv
module irqc_nest
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  lvl_t            take_lvl,
  input  logic            reti,
  output logic [NLVL-1:0] in_service
);
  logic [NLVL-1:0] top_bit, next_mask;

  always_comb begin
    top_bit = '0;
    for (int l = 0; l < NLVL; l++)
      if (in_service[l]) top_bit = NLVL'(1) << l;
  end

  always_comb begin
    next_mask = in_service;
    if (reti) next_mask = next_mask & ~top_bit;
    if (take) next_mask = next_mask | (NLVL'(1) << take_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_service <= '0;
    else        in_service <= next_mask;
  end

  // R5: an accepted level is recorded as in service
  a_r5_take_marks: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> in_service[$past(take_lvl)]);
  // R6: a return removes exactly one level
  a_r6_reti_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && in_service != '0) |=>
      ($countones(in_service) == $countones($past(in_service)) - 1));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gie,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  prio_hi,
  input  logic [NSRC-1:0]  prio_lo,
  input  logic [1:0]       ext_pin_n,
  input  logic [1:0]       ext_edge,
  input  logic [1:0]       tmr_ovf,
  input  logic [3:0]       hw_flag_clr,
  input  logic             ser_rx,
  input  logic             ser_tx,
  input  logic             spi_flag,
  input  logic             adc_flag,
  input  logic             pca_flag,
  input  logic             lvf_flag,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VEC_W-1:0] irq_vector,
  input  logic             reti
);
  logic [NSRC-1:0]           req, gated, take_hot;
  logic [NSRC-1:0][LVLW-1:0] src_lvl;
  logic [NLVL-1:0]           in_service;
  logic [1:0]                ext_req, tmr_flag;
  logic                      take;
  idx_t                      win_idx;
  lvl_t                      win_lvl;

  localparam int EXT_IDX [2] = '{S_EXT0, S_EXT1};
  localparam int TMR_IDX [2] = '{S_TMR0, S_TMR1};

  assign take     = irq_valid & irq_ready;
  assign take_hot = take ? (NSRC'(1) << win_idx) : '0;

  for (genvar k = 0; k < 2; k++) begin : g_ext
    irqc_ext_detect #(.SYNC(SYNC)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_n    (ext_pin_n[k]),
      .edge_mode(ext_edge[k]),
      .take_clr (take_hot[EXT_IDX[k]]),
      .sw_clr   (hw_flag_clr[EXT_IDX[k]]),
      .req      (ext_req[k])
    );
  end

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tmr_flag[t] <= 1'b0;
      else if (tmr_ovf[t]) tmr_flag[t] <= 1'b1;
      else if (take_hot[TMR_IDX[t]] || hw_flag_clr[TMR_IDX[t]])
                           tmr_flag[t] <= 1'b0;
    end
    // R9: an overflow pulse always leaves the timer flag set
    a_r9_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf[t] |=> tmr_flag[t]);
  end

  always_comb begin
    req         = '0;
    req[S_EXT0] = ext_req[0];
    req[S_TMR0] = tmr_flag[0];
    req[S_EXT1] = ext_req[1];
    req[S_TMR1] = tmr_flag[1];
    req[S_SER]  = ser_rx | ser_tx;
    req[S_SPAD] = spi_flag | adc_flag;
    req[S_PCLV] = pca_flag | lvf_flag;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_lvl
    assign src_lvl[i] = {prio_hi[i], prio_lo[i]};
  end

  assign gated = req & src_en & {NSRC{gie}};

  irqc_arbiter u_arb (
    .req       (gated),
    .src_lvl   (src_lvl),
    .in_service(in_service),
    .win_valid (irq_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  irqc_nest u_nest (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_lvl  (win_lvl),
    .reti      (reti),
    .in_service(in_service)
  );

  assign irq_vector = VEC_W'(VEC_BASE + int'(win_idx) * VEC_STEP);

  // R2: nothing is offered while the global enable is off
  a_r2_global_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> gie);
  // R4: every offered vector lies on the 8-byte grid starting at 3
  a_r4_vector_grid: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector[2:0] == 3'd3 && irq_vector < VEC_W'(VEC_BASE + NSRC*VEC_STEP)));
  // R5: the offered level is above every level held by the nesting record
  a_r5_above_service: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((in_service >> win_lvl) == '0));
endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
  logic        clk = 0, rst_n = 0, gie = 0;
  logic [6:0]  src_en = 0, prio_hi = 0, prio_lo = 0;
  logic [1:0]  ext_pin_n = 2'b11, ext_edge = 2'b01, tmr_ovf = 0;
  logic [3:0]  hw_flag_clr = 0;
  logic        ser_rx = 0, ser_tx = 0, spi_flag = 0, adc_flag = 0;
  logic        pca_flag = 0, lvf_flag = 0, irq_ready = 0, reti = 0;
  logic        irq_valid;
  logic [15:0] irq_vector;
  int          n_chk = 0, n_bad = 0;
  logic [15:0] exp_vec[$];
  string       exp_tag[$];

  always #4 clk = ~clk;

  irq_vector_ctrl uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // offered: check valid and vector together
  task automatic offer(input string tag, input logic [15:0] v);
    chk(tag, {15'd0, irq_valid}, 32'd1);
    chk(tag, {16'd0, irq_vector}, {16'd0, v});
  endtask

  // driver: push expectation, accept once; monitor pops at the negedge
  task automatic take(input string tag, input logic [15:0] v);
    exp_vec.push_back(v);
    exp_tag.push_back(tag);
    irq_ready = 1;
    step(1);
    irq_ready = 0;
    if (exp_vec.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL %s actual=no-transfer expected=%h", tag, v);
      exp_vec.delete(); exp_tag.delete();
    end
  endtask

  task automatic do_reti();
    reti = 1; step(1); reti = 0;
  endtask

  task automatic ovf(input logic [1:0] m);
    tmr_ovf = m; step(1); tmr_ovf = 0;
  endtask

  always @(negedge clk) begin
    if (irq_valid && irq_ready) begin
      if (exp_vec.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL unexpected transfer actual=%h expected=none", irq_vector);
      end else begin
        logic [15:0] ev;
        string et;
        ev = exp_vec.pop_front();
        et = exp_tag.pop_front();
        chk({et, " transfer"}, {16'd0, irq_vector}, {16'd0, ev});
      end
    end
  end

  initial begin
    #(8*100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk("R1 idle after reset", {31'd0, irq_valid}, 0);

    // R2 global enable, R9 timer flag cleared on acceptance
    src_en = 7'h7F;
    ovf(2'b01);
    chk("R2 gie off", {31'd0, irq_valid}, 0);
    gie = 1; step(1);
    offer("R9 timer0 offered", 16'h000B);
    take("R9", 16'h000B);
    do_reti();
    chk("R9 flag cleared", {31'd0, irq_valid}, 0);

    // R2 individual enable
    src_en[3] = 0;
    ovf(2'b10);
    chk("R2 src_en off", {31'd0, irq_valid}, 0);
    src_en[3] = 1; step(1);
    offer("R2 src_en on", 16'h001B);
    take("R2", 16'h001B);
    do_reti();
    chk("R9 timer1 cleared", {31'd0, irq_valid}, 0);

    // R4 polling order at one level, R10 serial not cleared
    ser_rx = 1;
    ovf(2'b11);
    offer("R4 first poll", 16'h000B);
    take("R4", 16'h000B);
    chk("R5 same level blocked", {31'd0, irq_valid}, 0);
    do_reti();
    offer("R4 second poll", 16'h001B);
    take("R4", 16'h001B);
    do_reti();
    offer("R4 serial", 16'h0023);
    take("R10", 16'h0023);
    do_reti();
    offer("R10 serial held", 16'h0023);
    ser_rx = 0; ser_tx = 1; step(1);
    offer("R10 tx OR", 16'h0023);
    ser_tx = 0; step(1);
    chk("R10 serial gone", {31'd0, irq_valid}, 0);

    // R3 level beats poll order
    prio_hi[3] = 1; prio_lo[1] = 1; prio_lo[5] = 1;
    ovf(2'b11);
    offer("R3 higher level", 16'h001B);
    take("R3", 16'h001B);
    chk("R5 lower blocked", {31'd0, irq_valid}, 0);
    do_reti();
    offer("R3 lower next", 16'h000B);
    take("R3", 16'h000B);            // level 1 in service
    ovf(2'b10);
    offer("R5 preempt", 16'h001B);
    take("R5", 16'h001B);            // levels 2,1 in service
    spi_flag = 1; step(1);
    chk("R5 level1 blocked", {31'd0, irq_valid}, 0);
    do_reti();
    chk("R6 lower still held", {31'd0, irq_valid}, 0);
    do_reti();
    offer("R6 after both returns", 16'h002B);
    take("R10", 16'h002B);
    do_reti();
    offer("R10 shared held", 16'h002B);
    spi_flag = 0; step(1);
    chk("R10 shared gone", {31'd0, irq_valid}, 0);
    prio_hi = 0; prio_lo = 0;

    // R12 no acceptance without ready
    ovf(2'b01);
    step(3);
    offer("R12 held offer", 16'h000B);
    take("R12", 16'h000B);
    do_reti();
    chk("R12 single transfer", {31'd0, irq_valid}, 0);

    // R7 edge mode on external 0
    ext_pin_n[0] = 0; step(4);
    offer("R7 edge offered", 16'h0003);
    take("R7", 16'h0003);
    do_reti(); step(1);
    chk("R7 cleared, pin still low", {31'd0, irq_valid}, 0);
    ext_pin_n[0] = 1; step(4);
    ext_pin_n[0] = 0; step(4);
    offer("R7 second edge", 16'h0003);
    hw_flag_clr[0] = 1; step(1); hw_flag_clr[0] = 0;
    chk("R7 software clear", {31'd0, irq_valid}, 0);
    ext_pin_n[0] = 1; step(4);

    // R11 set beats clear
    tmr_ovf[0] = 1; hw_flag_clr[1] = 1; step(1);
    tmr_ovf[0] = 0; hw_flag_clr[1] = 0;
    offer("R11 set wins", 16'h000B);
    take("R11", 16'h000B);
    do_reti();

    // R8 level mode on external 1
    ext_pin_n[1] = 0; step(3);
    offer("R8 level offered", 16'h0013);
    take("R8", 16'h0013);
    do_reti();
    offer("R8 not cleared", 16'h0013);
    ext_pin_n[1] = 1; step(3);
    chk("R8 follows pin", {31'd0, irq_valid}, 0);

    // R4 last source
    lvf_flag = 1; step(1);
    offer("R4 last source", 16'h0033);
    take("R4", 16'h0033);
    do_reti();
    lvf_flag = 0; step(1);
    chk("R10 pca/lvf gone", {31'd0, irq_valid}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule